// File: doc/BRIEF.md
# Age-Ordered Issue Queue With Operand Wakeup

This block is the waiting room between instruction dispatch and one function unit in an out-of-order core. Each dispatched instruction brings two source operands. A source either arrives as a finished value or as a 6-bit physical-register tag, naming one of 40 registers, that some producer will later resolve. The block also brings a literal and an opaque payload. The entry sits in one of 16 slots until all of its sources are known. The queue then hands the entry to the function unit when the unit can accept work.

Three result buses feed the queue. Each bus announces a producer's tag one cycle before it drives the matching result value. An entry that sees its tag in cycle T can therefore issue in cycle T+1, and it takes the value straight off the bus as it leaves. Dispatch also listens to the buses, so an instruction never misses a result that is being delivered while it enters. Among the entries that are ready, the one with the earliest dispatch cycle always goes first, whatever its slot position. A flush mask from the recovery logic removes squashed entries in one cycle.

Top module: `iq_core`

## Requirements
- R1: After synchronous reset the queue is empty: `full` is 0 and `iss_vld` stays 0 until something is dispatched.
- R2: A dispatch writes into the lowest-numbered free slot, and the slot index is reported on `iss_slot` when that entry issues.
- R3: A source dispatched with its ready bit set keeps the supplied value and is delivered unchanged at issue.
- R4: A waiting source whose tag was announced on bus b in the previous cycle captures the value that bus b carries during the dispatch cycle, and is ready at once.
- R5: A waiting source whose tag is announced on a bus during the dispatch cycle becomes ready in the next cycle. Its operand is the value that the same bus carries in that next cycle.
- R6: A queued source whose tag is announced in cycle T can issue in cycle T+1 using that bus's value from T+1. The value is kept in the entry if the entry does not issue then.
- R7: An entry cannot issue in the cycle in which it is dispatched.
- R8: Among the entries whose sources are all ready, the one dispatched earliest issues, independent of slot index.
- R9: Nothing issues while `fu_rdy` is 0, and the waiting entries are preserved.
- R10: An issued entry is freed in its issue cycle, so its slot can take a dispatch in the following cycle.
- R11: When all 16 slots are occupied, `full` is 1 and a dispatch in that cycle is dropped.
- R12: Every occupied slot whose bit is set in `flush_mask` is freed at the end of that cycle and does not issue in that cycle.
- R13: The three buses act independently: different sources can wake from different buses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | 1 | Dispatch request this cycle |
| disp_src_rdy | input | 2 | Per source: value already available |
| disp_src_tag | input | 2x6 | Per source: producer tag |
| disp_src_val | input | 2x32 | Per source: value when ready |
| disp_lit | input | 32 | Literal operand |
| disp_pay | input | 16 | Opaque payload |
| bc_tag_vld | input | 3 | Per bus: tag announcement valid |
| bc_tag | input | 3x6 | Per bus: announced tag |
| bc_val | input | 3x32 | Per bus: value of the tag announced in the previous cycle |
| flush_mask | input | 16 | Slots to squash this cycle |
| fu_rdy | input | 1 | Function unit accepts an instruction |
| full | output | 1 | All slots occupied |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_slot | output | 4 | Slot of the issuing entry |
| iss_opnd | output | 2x32 | Resolved source operands |
| iss_lit | output | 32 | Literal of the issuing entry |
| iss_pay | output | 16 | Payload of the issuing entry |

## Verification
The hardest situations to reach are timing coincidences. One is a dispatch that lands exactly on a tag announcement or on the following value cycle. Another is several entries waking on different buses in one cycle while an older entry in a higher slot competes for issue. Directed sequences build each of these by hand. A long random phase then uses only eight distinct tags, so announcements often collide with waiting and freshly dispatched sources. In that phase `fu_rdy` drops often, which keeps the queue near full, and random flush masks arrive now and then. A cycle-level model in the bench predicts every issue.

// File: rtl/iq_pkg.sv
package iq_pkg;

    parameter int IQ_TAG_W   = 6;
    parameter int IQ_DATA_W  = 32;
    parameter int IQ_NUM_BUS = 3;
    parameter int IQ_NUM_SRC = 2;
    parameter int IQ_PAY_W   = 16;
    parameter int IQ_STAMP_W = 32;
    localparam int IQ_BUS_W  = (IQ_NUM_BUS > 1) ? $clog2(IQ_NUM_BUS) : 1;

    typedef struct packed {
        logic                 rdy;
        logic                 pend;
        logic [IQ_BUS_W-1:0]  bus;
        logic [IQ_TAG_W-1:0]  tag;
        logic [IQ_DATA_W-1:0] val;
    } iq_src_t;

    typedef logic [IQ_NUM_BUS-1:0][IQ_TAG_W-1:0]  iq_bus_tags_t;
    typedef logic [IQ_NUM_BUS-1:0][IQ_DATA_W-1:0] iq_bus_vals_t;

    // Pick the value of one bus by index.
    function automatic logic [IQ_DATA_W-1:0] iq_bus_pick(
        input iq_bus_vals_t        vals,
        input logic [IQ_BUS_W-1:0] idx
    );
        logic [IQ_DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < IQ_NUM_BUS; b++) begin
            if (idx == IQ_BUS_W'(b)) r = vals[b];
        end
        return r;
    endfunction

    // Build the stored source state of a new entry, snooping the buses.
    function automatic iq_src_t iq_snoop_src(
        input logic                  rdy,
        input logic [IQ_TAG_W-1:0]   tag,
        input logic [IQ_DATA_W-1:0]  val,
        input logic [IQ_NUM_BUS-1:0] tv_now,
        input iq_bus_tags_t          t_now,
        input logic [IQ_NUM_BUS-1:0] tv_prev,
        input iq_bus_tags_t          t_prev,
        input iq_bus_vals_t          v_now
    );
        iq_src_t             s;
        logic                hit_v;
        logic                hit_t;
        logic [IQ_BUS_W-1:0] vb;
        logic [IQ_BUS_W-1:0] tb;
        s     = '{rdy: rdy, pend: 1'b0, bus: '0, tag: tag, val: val};
        hit_v = 1'b0;
        hit_t = 1'b0;
        vb    = '0;
        tb    = '0;
        for (int b = IQ_NUM_BUS - 1; b >= 0; b--) begin
            if (tv_prev[b] && t_prev[b] == tag) begin
                hit_v = 1'b1;
                vb    = IQ_BUS_W'(b);
            end
            if (tv_now[b] && t_now[b] == tag) begin
                hit_t = 1'b1;
                tb    = IQ_BUS_W'(b);
            end
        end
        if (!rdy) begin
            if (hit_v) begin
                s.rdy = 1'b1;
                s.val = iq_bus_pick(v_now, vb);
            end else if (hit_t) begin
                s.pend = 1'b1;
                s.bus  = tb;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/iq_free_pick.sv
module iq_free_pick
    #(parameter int DEPTH = 16,
      localparam int IDX_W = $clog2(DEPTH))
    (
    input  logic [DEPTH-1:0] occ,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
    );

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/iq_age_select.sv
module iq_age_select
    #(parameter int DEPTH = 16,
      parameter int STAMP_W = 32,
      localparam int IDX_W = $clog2(DEPTH))
    (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [DEPTH-1:0]                elig,
    input  logic [DEPTH-1:0][STAMP_W-1:0]   stamps,
    output logic                            sel_vld,
    output logic [IDX_W-1:0]                sel_idx
    );

    logic [STAMP_W-1:0] best;

    always_comb begin
        sel_vld = 1'b0;
        sel_idx = '0;
        best    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!sel_vld || stamps[i] < best)) begin
                sel_vld = 1'b1;
                sel_idx = IDX_W'(i);
                best    = stamps[i];
            end
        end
    end

    generate
        for (genvar j = 0; j < DEPTH; j++) begin : g_age_chk
            // R8
            oldest_pick_chk: assert property (@(posedge clk) disable iff (rst)
                (sel_vld && elig[j]) |-> (stamps[sel_idx] <= stamps[j]));
        end
    endgenerate

endmodule

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
    (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  iq_src_t [IQ_NUM_SRC-1:0]             wr_src,
    input  logic [IQ_DATA_W-1:0]                 wr_lit,
    input  logic [IQ_PAY_W-1:0]                  wr_pay,
    input  logic [IQ_STAMP_W-1:0]                wr_stamp,
    input  logic                                 clr,
    input  logic [IQ_NUM_BUS-1:0]                bc_tag_vld,
    input  iq_bus_tags_t                         bc_tag,
    input  iq_bus_vals_t                         bc_val,
    output logic                                 occ,
    output logic                                 ready,
    output logic [IQ_STAMP_W-1:0]                stamp,
    output logic [IQ_NUM_SRC-1:0][IQ_DATA_W-1:0] opnd,
    output logic [IQ_DATA_W-1:0]                 lit,
    output logic [IQ_PAY_W-1:0]                  pay
    );

    logic                         occ_q;
    iq_src_t [IQ_NUM_SRC-1:0]     src_q;
    logic [IQ_STAMP_W-1:0]        stamp_q;
    logic [IQ_DATA_W-1:0]         lit_q;
    logic [IQ_PAY_W-1:0]          pay_q;
    logic [IQ_NUM_SRC-1:0]        wake_hit;
    logic [IQ_NUM_SRC-1:0][IQ_BUS_W-1:0] wake_bus;
    logic [IQ_NUM_SRC-1:0]        src_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= 1'b0;
        end else if (wr_en) begin
            occ_q <= 1'b1;
        end else if (clr) begin
            occ_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= '0;
            lit_q   <= '0;
            pay_q   <= '0;
        end else if (wr_en) begin
            stamp_q <= wr_stamp;
            lit_q   <= wr_lit;
            pay_q   <= wr_pay;
        end
    end

    generate
        for (genvar s = 0; s < IQ_NUM_SRC; s++) begin : g_src
            always_comb begin
                wake_hit[s] = 1'b0;
                wake_bus[s] = '0;
                for (int b = IQ_NUM_BUS - 1; b >= 0; b--) begin
                    if (bc_tag_vld[b] && bc_tag[b] == src_q[s].tag) begin
                        wake_hit[s] = 1'b1;
                        wake_bus[s] = IQ_BUS_W'(b);
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    src_q[s] <= '0;
                end else if (wr_en) begin
                    src_q[s] <= wr_src[s];
                end else if (occ_q) begin
                    if (src_q[s].pend) begin
                        src_q[s].rdy  <= 1'b1;
                        src_q[s].pend <= 1'b0;
                        src_q[s].val  <= iq_bus_pick(bc_val, src_q[s].bus);
                    end else if (!src_q[s].rdy && wake_hit[s]) begin
                        src_q[s].pend <= 1'b1;
                        src_q[s].bus  <= wake_bus[s];
                    end
                end
            end

            assign src_ok[s] = src_q[s].rdy || src_q[s].pend;
            assign opnd[s]   = src_q[s].rdy ? src_q[s].val
                                            : iq_bus_pick(bc_val, src_q[s].bus);

            // R6
            pend_resolves_chk: assert property (@(posedge clk) disable iff (rst)
                (occ_q && src_q[s].pend && !wr_en) |=> src_q[s].rdy && !src_q[s].pend);
        end
    endgenerate

    assign occ   = occ_q;
    assign ready = occ_q && (&src_ok);
    assign stamp = stamp_q;
    assign lit   = lit_q;
    assign pay   = pay_q;

    // R12
    clr_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr_en) |=> !occ_q);

endmodule

// File: rtl/iq_core.sv
module iq_core
    import iq_pkg::*;
    #(parameter int DEPTH = 16,
      localparam int IDX_W = $clog2(DEPTH))
    (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 disp_vld,
    input  logic [IQ_NUM_SRC-1:0]                disp_src_rdy,
    input  logic [IQ_NUM_SRC-1:0][IQ_TAG_W-1:0]  disp_src_tag,
    input  logic [IQ_NUM_SRC-1:0][IQ_DATA_W-1:0] disp_src_val,
    input  logic [IQ_DATA_W-1:0]                 disp_lit,
    input  logic [IQ_PAY_W-1:0]                  disp_pay,
    input  logic [IQ_NUM_BUS-1:0]                bc_tag_vld,
    input  logic [IQ_NUM_BUS-1:0][IQ_TAG_W-1:0]  bc_tag,
    input  logic [IQ_NUM_BUS-1:0][IQ_DATA_W-1:0] bc_val,
    input  logic [DEPTH-1:0]                     flush_mask,
    input  logic                                 fu_rdy,
    output logic                                 full,
    output logic                                 iss_vld,
    output logic [IDX_W-1:0]                     iss_slot,
    output logic [IQ_NUM_SRC-1:0][IQ_DATA_W-1:0] iss_opnd,
    output logic [IQ_DATA_W-1:0]                 iss_lit,
    output logic [IQ_PAY_W-1:0]                  iss_pay
    );

    logic [IQ_STAMP_W-1:0]              cyc_q;
    logic [IQ_NUM_BUS-1:0]              tvld_q;
    iq_bus_tags_t                       tag_q;

    logic [DEPTH-1:0]                   ent_occ;
    logic [DEPTH-1:0]                   ent_rdy;
    logic [DEPTH-1:0][IQ_STAMP_W-1:0]   ent_stamp;
    logic [IQ_NUM_SRC-1:0][IQ_DATA_W-1:0] ent_opnd [DEPTH];
    logic [IQ_DATA_W-1:0]               ent_lit [DEPTH];
    logic [IQ_PAY_W-1:0]                ent_pay [DEPTH];

    logic                               any_free;
    logic [IDX_W-1:0]                   free_idx;
    logic                               disp_fire;
    iq_src_t [IQ_NUM_SRC-1:0]           new_src;
    logic [DEPTH-1:0]                   elig;
    logic                               sel_vld;
    logic [IDX_W-1:0]                   sel_idx;

    // Dispatch stamp source and one-cycle history of announced tags.
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            tvld_q <= '0;
            tag_q  <= '0;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
            tvld_q <= bc_tag_vld;
            tag_q  <= bc_tag;
        end
    end

    iq_free_pick #(.DEPTH(DEPTH)) u_free (
        .occ      (ent_occ),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    assign full      = !any_free;
    assign disp_fire = disp_vld && any_free;

    generate
        for (genvar s = 0; s < IQ_NUM_SRC; s++) begin : g_snoop
            assign new_src[s] = iq_snoop_src(disp_src_rdy[s], disp_src_tag[s],
                                             disp_src_val[s], bc_tag_vld, bc_tag,
                                             tvld_q, tag_q, bc_val);
        end

        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            logic wr_i;
            logic clr_i;
            assign wr_i  = disp_fire && (free_idx == IDX_W'(i));
            assign clr_i = flush_mask[i] || (iss_vld && sel_idx == IDX_W'(i));

            iq_entry u_ent (
                .clk        (clk),
                .rst        (rst),
                .wr_en      (wr_i),
                .wr_src     (new_src),
                .wr_lit     (disp_lit),
                .wr_pay     (disp_pay),
                .wr_stamp   (cyc_q),
                .clr        (clr_i),
                .bc_tag_vld (bc_tag_vld),
                .bc_tag     (bc_tag),
                .bc_val     (bc_val),
                .occ        (ent_occ[i]),
                .ready      (ent_rdy[i]),
                .stamp      (ent_stamp[i]),
                .opnd       (ent_opnd[i]),
                .lit        (ent_lit[i]),
                .pay        (ent_pay[i])
            );

            assign elig[i] = ent_rdy[i] && !flush_mask[i];
        end
    endgenerate

    iq_age_select #(.DEPTH(DEPTH), .STAMP_W(IQ_STAMP_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .elig    (elig),
        .stamps  (ent_stamp),
        .sel_vld (sel_vld),
        .sel_idx (sel_idx)
    );

    assign iss_vld  = sel_vld && fu_rdy;
    assign iss_slot = sel_idx;
    assign iss_opnd = ent_opnd[sel_idx];
    assign iss_lit  = ent_lit[sel_idx];
    assign iss_pay  = ent_pay[sel_idx];

    // R10
    issue_frees_chk: assert property (@(posedge clk) disable iff (rst)
        iss_vld |=> !ent_occ[$past(iss_slot)]);

    // R11
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !iss_vld && flush_mask == '0) |=> full);

    // R12
    flushed_not_issued_chk: assert property (@(posedge clk) disable iff (rst)
        iss_vld |-> !flush_mask[iss_slot]);

endmodule

// File: tb/iq_core_tb_top.sv
module iq_core_tb_top;
    import iq_pkg::*;

    localparam int D  = 16;
    localparam int NS = IQ_NUM_SRC;
    localparam int NB = IQ_NUM_BUS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                          d_vld;
    logic [NS-1:0]                 d_rdy;
    logic [NS-1:0][IQ_TAG_W-1:0]   d_tag;
    logic [NS-1:0][IQ_DATA_W-1:0]  d_val;
    logic [IQ_DATA_W-1:0]          d_lit;
    logic [IQ_PAY_W-1:0]           d_pay;
    logic [NB-1:0]                 b_tv;
    logic [NB-1:0][IQ_TAG_W-1:0]   b_tag;
    logic [NB-1:0][IQ_DATA_W-1:0]  b_val;
    logic [D-1:0]                  f_mask;
    logic                          f_rdy;
    logic                          full;
    logic                          iss_vld;
    logic [3:0]                    iss_slot;
    logic [NS-1:0][IQ_DATA_W-1:0]  iss_opnd;
    logic [IQ_DATA_W-1:0]          iss_lit;
    logic [IQ_PAY_W-1:0]           iss_pay;

    iq_core dut_i (
        .clk(clk), .rst(rst), .disp_vld(d_vld), .disp_src_rdy(d_rdy),
        .disp_src_tag(d_tag), .disp_src_val(d_val), .disp_lit(d_lit),
        .disp_pay(d_pay), .bc_tag_vld(b_tv), .bc_tag(b_tag), .bc_val(b_val),
        .flush_mask(f_mask), .fu_rdy(f_rdy), .full(full), .iss_vld(iss_vld),
        .iss_slot(iss_slot), .iss_opnd(iss_opnd), .iss_lit(iss_lit),
        .iss_pay(iss_pay)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference state of the queue.
    bit                   m_occ [D];
    int                   m_age [D];
    bit                   m_rdy [D][NS];
    bit                   m_pend[D][NS];
    int                   m_bus [D][NS];
    logic [IQ_TAG_W-1:0]  m_tag [D][NS];
    logic [IQ_DATA_W-1:0] m_val [D][NS];
    logic [IQ_DATA_W-1:0] m_lit [D];
    logic [IQ_PAY_W-1:0]  m_pay [D];
    bit                   p_tv  [NB];
    logic [IQ_TAG_W-1:0]  p_tag [NB];
    int                   m_cyc;
    bit                   e_full;
    bit                   e_iss;
    int                   e_slot;

    task automatic check(input string lbl, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", lbl, what, got, exp);
        end
    endtask

    function automatic bit m_ready(input int i);
        bit r = 1'b1;
        for (int s = 0; s < NS; s++) r = r && (m_rdy[i][s] || m_pend[i][s]);
        return r;
    endfunction

    function automatic logic [IQ_DATA_W-1:0] m_opnd(input int i, input int s);
        return m_rdy[i][s] ? m_val[i][s] : b_val[m_bus[i][s]];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < D; i++) begin
            m_occ[i] = 1'b0;
            for (int s = 0; s < NS; s++) begin
                m_rdy[i][s] = 1'b0; m_pend[i][s] = 1'b0;
            end
        end
        for (int b = 0; b < NB; b++) p_tv[b] = 1'b0;
        m_cyc = 0;
    endtask

    task automatic idle_inputs();
        d_vld = 0; d_rdy = '0; d_tag = '0; d_val = '0; d_lit = '0; d_pay = '0;
        b_tv = '0; b_tag = '0; b_val = '0; f_mask = '0; f_rdy = 1'b0;
    endtask

    task automatic compute_expect();
        int best = -1;
        e_full = 1'b1;
        for (int i = 0; i < D; i++) if (!m_occ[i]) e_full = 1'b0;
        for (int i = 0; i < D; i++)
            if (m_occ[i] && !f_mask[i] && m_ready(i) && (best < 0 || m_age[i] < m_age[best]))
                best = i;
        e_iss  = f_rdy && best >= 0;
        e_slot = best;
    endtask

    task automatic model_update();
        int slot = -1;
        for (int i = D - 1; i >= 0; i--) if (!m_occ[i]) slot = i;
        if (e_iss) m_occ[e_slot] = 1'b0;
        for (int i = 0; i < D; i++) if (f_mask[i]) m_occ[i] = 1'b0;
        for (int i = 0; i < D; i++) begin
            if (!m_occ[i]) continue;
            for (int s = 0; s < NS; s++) begin
                if (m_pend[i][s]) begin
                    m_rdy[i][s] = 1'b1; m_pend[i][s] = 1'b0;
                    m_val[i][s] = b_val[m_bus[i][s]];
                end else if (!m_rdy[i][s]) begin
                    for (int b = NB - 1; b >= 0; b--)
                        if (b_tv[b] && b_tag[b] == m_tag[i][s]) begin
                            m_pend[i][s] = 1'b1; m_bus[i][s] = b;
                        end
                end
            end
        end
        if (d_vld && !e_full) begin
            m_occ[slot] = 1'b1; m_age[slot] = m_cyc;
            m_lit[slot] = d_lit; m_pay[slot] = d_pay;
            for (int s = 0; s < NS; s++) begin
                int vb = -1;
                int tb = -1;
                m_tag[slot][s] = d_tag[s]; m_val[slot][s] = d_val[s];
                m_rdy[slot][s] = d_rdy[s]; m_pend[slot][s] = 1'b0;
                for (int b = NB - 1; b >= 0; b--) begin
                    if (p_tv[b] && p_tag[b] == d_tag[s]) vb = b;
                    if (b_tv[b] && b_tag[b] == d_tag[s]) tb = b;
                end
                if (!d_rdy[s]) begin
                    if (vb >= 0) begin
                        m_rdy[slot][s] = 1'b1; m_val[slot][s] = b_val[vb];
                    end else if (tb >= 0) begin
                        m_pend[slot][s] = 1'b1; m_bus[slot][s] = tb;
                    end
                end
            end
        end
        for (int b = 0; b < NB; b++) begin
            p_tv[b] = b_tv[b]; p_tag[b] = b_tag[b];
        end
        m_cyc++;
    endtask

    // One cycle: inputs are already set just after the previous edge.
    task automatic step(input string lbl);
        #8;
        compute_expect();
        check("R11", "full", 64'(full), 64'(e_full));
        check(lbl, "iss_vld", 64'(iss_vld), 64'(e_iss));
        if (e_iss && iss_vld) begin
            check(lbl, "slot", 64'(iss_slot), 64'(e_slot));
            for (int s = 0; s < NS; s++)
                check(lbl, "opnd", 64'(iss_opnd[s]), 64'(m_opnd(e_slot, s)));
            check(lbl, "lit", 64'(iss_lit), 64'(m_lit[e_slot]));
            check(lbl, "pay", 64'(iss_pay), 64'(m_pay[e_slot]));
        end
        @(posedge clk);
        #1;
        model_update();
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
    endtask

    task automatic disp(input bit r0, input int t0, input int v0,
                        input bit r1, input int t1, input int v1, input int pay);
        d_vld = 1'b1;
        d_rdy = {r1, r0};
        d_tag[0] = IQ_TAG_W'(t0); d_tag[1] = IQ_TAG_W'(t1);
        d_val[0] = IQ_DATA_W'(v0); d_val[1] = IQ_DATA_W'(v1);
        d_lit = IQ_DATA_W'(pay * 7);
        d_pay = IQ_PAY_W'(pay);
    endtask

    task automatic bcast(input int b, input int tag);
        b_tv[b] = 1'b1; b_tag[b] = IQ_TAG_W'(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        do_reset();
        // R1: empty after reset
        step("R1");
        step("R1");

        // R7 and R3: ready operands, unit ready, still no issue in dispatch cycle
        f_rdy = 1'b1; disp(1, 1, 32'h11, 1, 2, 32'h22, 101); step("R7");
        f_rdy = 1'b1; step("R3");

        // R9: unit stalled keeps entries; R2 lowest free slot; R8 oldest wins
        disp(1, 0, 32'hA0, 1, 0, 32'hA1, 201); step("R9");
        disp(1, 0, 32'hB0, 1, 0, 32'hB1, 202); step("R9");
        disp(1, 0, 32'hC0, 1, 0, 32'hC1, 203); step("R9");
        f_rdy = 1'b1; step("R8");
        disp(1, 0, 32'hD0, 1, 0, 32'hD1, 204); step("R10");
        f_rdy = 1'b1; step("R8");
        f_rdy = 1'b1; step("R8");
        f_rdy = 1'b1; step("R2");

        // R4: value of tag 9 on bus 1 during dispatch
        bcast(1, 9); step("R4");
        b_val[1] = 32'h9999; disp(0, 9, 0, 1, 0, 32'h5, 301); step("R4");
        b_val[1] = 32'hDEAD; f_rdy = 1'b1; step("R4");

        // R5: tag on bus 2 during dispatch, value next cycle
        bcast(2, 12); disp(0, 12, 0, 1, 0, 32'h6, 302); step("R5");
        b_val[2] = 32'h1212; f_rdy = 1'b1; step("R5");

        // R6 and R13: two waiting sources wake from buses 0 and 2 together
        disp(0, 3, 0, 0, 5, 0, 401); step("R13");
        step("R13");
        bcast(0, 3); bcast(2, 5); step("R13");
        b_val[0] = 32'h3333; b_val[2] = 32'h5555; step("R6");
        b_val[0] = 32'h0; b_val[2] = 32'h0; f_rdy = 1'b1; step("R6");

        // R11: fill the queue, then a dropped dispatch
        for (int k = 0; k < D; k++) begin
            disp(1, 0, k, 1, 0, k + 100, 500 + k); step("R11");
        end
        disp(1, 0, 32'hBAD, 1, 0, 32'hBAD, 999); step("R11");

        // R12: flush some slots while the unit is ready
        f_mask = 16'h00FF; f_rdy = 1'b1; step("R12");
        for (int k = 0; k < 10; k++) begin
            f_rdy = 1'b1; step("R12");
        end

        // Random phase
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            d_vld = ($urandom % 3) != 0;
            for (int s = 0; s < NS; s++) begin
                d_rdy[s] = ($urandom % 5) < 2;
                d_tag[s] = IQ_TAG_W'($urandom % 8);
                d_val[s] = $urandom;
            end
            d_lit = $urandom;
            d_pay = IQ_PAY_W'($urandom);
            for (int b = 0; b < NB; b++) begin
                b_tv[b]  = ($urandom % 2) == 0;
                b_tag[b] = IQ_TAG_W'($urandom % 8);
                b_val[b] = $urandom;
            end
            f_rdy  = ($urandom % 4) != 0;
            f_mask = (($urandom % 50) == 0) ? D'($urandom) : '0;
            step("R8");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule